// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Character Receiver

This block turns one asynchronous serial line into parallel characters. An enable pulse arrives at sixteen times the bit rate. The block uses that pulse to find a falling edge that starts a frame. It confirms the start bit half a bit later, then samples every data, parity and stop bit in the middle of its period. The enable itself comes from a divisor counter outside the block. That divisor is the oscillator frequency divided by sixteen times the baud rate.

Software sets the frame format through a control byte. The byte selects five to eight data bits, turns parity on or off, and picks odd or even parity. When a character completes, the block pulses a one-cycle strobe. Along with the strobe it presents the character and three flags: parity error, framing error and break.

The serial line is resynchronised through a two-flop chain before any sampling. A loopback select can route the local transmitter's line into the receiver in place of the external pin. FIFO storage and register access sit outside this block.

Top module: `serial_rx_core`

## Requirements
- R1: After synchronous reset, `char_valid`, `char_data`, `par_err`, `frm_err` and `brk_flag` are all zero.
- R2: `fmt_ctl[1:0]` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant first, and the unused upper bits of `char_data` read as zero.
- R3: `fmt_ctl[3]`=1 adds a parity bit after the data. `fmt_ctl[4]`=1 asks for even parity over data plus parity bit, and 0 asks for odd parity. `par_err` is set when the received parity does not match, and it is always zero while parity is off.
- R4: Only the first stop bit is checked. `fmt_ctl[2]` has no effect on the receiver, so a start bit that directly follows a single stop bit is received.
- R5: A low first stop bit in a frame that is not all space gives the character with `frm_err`=1. The receiver then resynchronises and the next frame is received normally.
- R6: A frame that is space from the start bit through the stop bit yields exactly one character with `char_data`=0, `brk_flag`=1, `par_err`=0 and `frm_err`=0. No further character follows until the line has returned to mark.
- R7: The start bit is checked again eight ticks after the falling edge is seen. A low pulse shorter than that returns the receiver to idle without any character.
- R8: With `loop_en`=1 the receiver listens to `loop_tx` and ignores `serial_in`. With `loop_en`=0 it listens to `serial_in` and ignores `loop_tx`.
- R9: `char_valid` is a single-cycle pulse. `char_data` and the flags hold their values between pulses.
- R10: The line is sampled only on `tick16`. `char_valid` rises only in the cycle after a tick, and with no ticks no character is ever produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| fmt_ctl | input | 8 | Format byte: [1:0] length, [2] stop setting, [3] parity on, [4] even parity |
| serial_in | input | 1 | External serial line, idle high |
| loop_en | input | 1 | Select the local transmit line as the source |
| loop_tx | input | 1 | Local transmit line used in loopback |
| char_valid | output | 1 | One-cycle strobe for a completed character |
| char_data | output | 8 | Received character, zero-extended |
| par_err | output | 1 | Parity mismatch on this character |
| frm_err | output | 1 | First stop bit was low |
| brk_flag | output | 1 | Character is a break indication |

## Verification
If the tick counter is off, samples drift away from the middle of each bit. The error shows as wrong data bits on the very next strobe, or as a missing strobe. If the bit index or the length decode is wrong, the strobe arrives one or more bit times early or late. That in turn shifts the data, parity and stop bit positions, so `frm_err` or `par_err` turns up on a clean frame within that same character. If the receiver fails to leave or enter the break-wait state, a held-low line produces either repeated zero characters about every ten bit times, or no break strobe at all. Both cases are visible before the line returns to mark.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKW
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_even;
    } rx_fmt_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
        logic              brk;
    } rx_char_t;

    function automatic rx_fmt_t decode_fmt(input logic [1:0] len, input logic pen, input logic peven);
        rx_fmt_t f;
        f.len_sel  = len;
        f.par_en   = pen;
        f.par_even = peven;
        return f;
    endfunction

    // index of the last data bit: 4 for five bits up to 7 for eight bits
    function automatic logic [2:0] last_index(input logic [1:0] sel);
        return 3'd4 + {1'b0, sel};
    endfunction

    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] sel);
        logic [CHAR_W-1:0] m;
        m = '0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i <= int'(last_index(sel))) m[i] = 1'b1;
        end
        return m;
    endfunction

    // high when data plus parity bit do not give the requested sense
    function automatic logic parity_fault(input logic [CHAR_W-1:0] d, input logic pbit, input logic even);
        return (^d) ^ pbit ^ ~even;
    endfunction

endpackage

// File: rtl/rx_line_front.sv
module rx_line_front #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          HAS_LOOP    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic serial_in,
    input  logic loop_en,
    input  logic loop_tx,
    output logic rx_s
);

    logic                   line_sel;
    logic [SYNC_STAGES-1:0] chain;

    generate
        if (HAS_LOOP) begin : g_loop
            assign line_sel = loop_en ? loop_tx : serial_in;
        end else begin : g_direct
            logic unused_loop;
            assign unused_loop = loop_en ^ loop_tx;
            assign line_sel    = serial_in;
        end
    endgenerate

    // the chain resets to mark so no false start follows reset
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], line_sel};
        end
    end

    assign rx_s = chain[SYNC_STAGES-1];

endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import serial_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx,
    input  rx_fmt_t  fmt_in,
    output logic     done,
    output rx_char_t res,
    output rx_fmt_t  fmt_q
);

    localparam int unsigned     CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        idx;
    logic [CHAR_W-1:0] shreg;
    logic              pbit;
    logic              all_space;

    assign all_space = !rx && (shreg == '0) && !(fmt_q.par_en && pbit);

    always_comb begin
        done        = tick && (st == ST_STOP) && (cnt == LAST);
        res.data    = shreg;
        res.brk     = all_space;
        res.frm_err = !rx && !all_space;
        res.par_err = fmt_q.par_en && !all_space
                      && parity_fault(shreg, pbit, fmt_q.par_even);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            fmt_q <= '0;
        end else if (tick) begin
            unique case (st)
                ST_IDLE: begin
                    if (!rx) begin
                        st    <= ST_START;
                        cnt   <= '0;
                        idx   <= '0;
                        shreg <= '0;
                        pbit  <= 1'b0;
                        fmt_q <= fmt_in;
                    end
                end
                ST_START: begin
                    if (cnt == MID) begin
                        cnt <= '0;
                        st  <= rx ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == LAST) begin
                        cnt        <= '0;
                        shreg[idx] <= rx;
                        if (idx == last_index(fmt_q.len_sel)) begin
                            st <= fmt_q.par_en ? ST_PAR : ST_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        pbit <= rx;
                        st   <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        st  <= all_space ? ST_BRKW : ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_BRKW: begin
                    if (rx) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage
    import serial_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     done,
    input  rx_char_t res,
    output logic     valid,
    output rx_char_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else begin
            valid <= done;
            if (done) q <= res;
        end
    end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          HAS_LOOP    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic [7:0]        fmt_ctl,
    input  logic              serial_in,
    input  logic              loop_en,
    input  logic              loop_tx,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data,
    output logic              par_err,
    output logic              frm_err,
    output logic              brk_flag
);

    logic     rx_s;
    logic     done;
    rx_char_t res;
    rx_char_t q;
    rx_fmt_t  fmt_in;
    rx_fmt_t  fmt_q;
    logic     unused_ctl;

    // the stop-bit setting and upper bits do not concern the receiver
    assign unused_ctl = ^{fmt_ctl[7:5], fmt_ctl[2]};
    assign fmt_in     = decode_fmt(fmt_ctl[1:0], fmt_ctl[3], fmt_ctl[4]);

    rx_line_front #(
        .SYNC_STAGES (SYNC_STAGES),
        .HAS_LOOP    (HAS_LOOP)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .serial_in (serial_in),
        .loop_en   (loop_en),
        .loop_tx   (loop_tx),
        .rx_s      (rx_s)
    );

    rx_deframer #(
        .OSR (OSR)
    ) u_deframer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick16),
        .rx     (rx_s),
        .fmt_in (fmt_in),
        .done   (done),
        .res    (res),
        .fmt_q  (fmt_q)
    );

    rx_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .done  (done),
        .res   (res),
        .valid (char_valid),
        .q     (q)
    );

    assign char_data = q.data;
    assign par_err   = q.par_err;
    assign frm_err   = q.frm_err;
    assign brk_flag  = q.brk;

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk
    import serial_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick16,
    input logic              char_valid,
    input logic [CHAR_W-1:0] char_data,
    input logic              par_err,
    input logic              frm_err,
    input logic              brk_flag,
    input rx_fmt_t           fmt_q
);

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !char_valid |-> $stable(char_data));

    // R10
    tick_origin_chk: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> $past(tick16));

    // R6
    break_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (char_valid && brk_flag) |-> (char_data == '0 && !par_err && !frm_err));

    // R2
    width_mask_chk: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> ((char_data & ~len_mask(fmt_q.len_sel)) == '0));

    // R3
    no_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (char_valid && !fmt_q.par_en) |-> !par_err);

endmodule

bind serial_rx_core serial_rx_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .tick16     (tick16),
    .char_valid (char_valid),
    .char_data  (char_data),
    .par_err    (par_err),
    .frm_err    (frm_err),
    .brk_flag   (brk_flag),
    .fmt_q      (fmt_q)
);

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;

    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic [7:0] fmt = 8'h03;
    logic       ser = 1'b1;
    logic       loop_en = 1'b0;
    logic       ltx = 1'b1;
    logic       char_valid;
    logic [7:0] char_data;
    logic       par_err, frm_err, brk_flag;

    int  total = 0;
    int  fails = 0;
    int  nval = 0;
    int  width = 0;
    int  maxw = 0;
    int  tdiv = 0;
    bit  tick_on = 1'b1;
    logic [7:0] c_data = '0;
    logic c_par = 1'b0, c_frm = 1'b0, c_brk = 1'b0;

    always #4 clk = ~clk;

    serial_rx_core i_serial_rx_core (
        .clk        (clk),
        .rst        (rst),
        .tick16     (tick16),
        .fmt_ctl    (fmt),
        .serial_in  (ser),
        .loop_en    (loop_en),
        .loop_tx    (ltx),
        .char_valid (char_valid),
        .char_data  (char_data),
        .par_err    (par_err),
        .frm_err    (frm_err),
        .brk_flag   (brk_flag)
    );

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick16 <= tick_on && (tdiv == 0);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (char_valid) begin
                nval++;
                width++;
                c_data = char_data;
                c_par  = par_err;
                c_frm  = frm_err;
                c_brk  = brk_flag;
            end else begin
                width = 0;
            end
            if (width > maxw) maxw = width;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hold_clk(input bit v, input bit on_loop, input int nclk);
        if (on_loop) ltx = v; else ser = v;
        repeat (nclk) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nbits, input bit pen, input bit peven,
                        input bit pflip, input bit stopv, input int idle_bits, input bit on_loop);
        logic [7:0] m;
        logic       p;
        m = 8'((1 << nbits) - 1);
        hold_clk(1'b0, on_loop, BITCLK);
        for (int i = 0; i < nbits; i++) hold_clk(d[i], on_loop, BITCLK);
        if (pen) begin
            p = peven ? ^(d & m) : ~^(d & m);
            hold_clk(p ^ pflip, on_loop, BITCLK);
        end
        hold_clk(stopv, on_loop, BITCLK);
        if (idle_bits > 0) hold_clk(1'b1, on_loop, idle_bits * BITCLK);
    endtask

    task automatic expect_char(input string req, input int n0, input int d,
                               input int pe, input int fe, input int be);
        chk(req, "strobe count", nval - n0, 1);
        chk(req, "data", c_data, d);
        chk(req, "par_err", c_par, pe);
        chk(req, "frm_err", c_frm, fe);
        chk(req, "brk_flag", c_brk, be);
    endtask

    task automatic t_reset;
        chk("R1", "char_valid", char_valid, 0);
        chk("R1", "char_data", char_data, 0);
        chk("R1", "flags", {par_err, frm_err, brk_flag}, 0);
    endtask

    task automatic t_lengths;
        for (int l = 0; l < 4; l++) begin
            int n0;
            fmt = {6'b0, 2'(l)};
            n0  = nval;
            send(8'hB7, 5 + l, 0, 0, 0, 1, 2, 0);
            expect_char("R2", n0, 8'hB7 & 8'((1 << (5 + l)) - 1), 0, 0, 0);
        end
    endtask

    task automatic t_parity;
        int n0;
        fmt = 8'b0001_1011; n0 = nval;              // 8 bits, even
        send(8'h3C, 8, 1, 1, 0, 1, 2, 0);
        expect_char("R3", n0, 8'h3C, 0, 0, 0);
        n0 = nval;
        send(8'h3D, 8, 1, 1, 1, 1, 2, 0);
        expect_char("R3", n0, 8'h3D, 1, 0, 0);
        fmt = 8'b0000_1010; n0 = nval;              // 7 bits, odd
        send(8'h07, 7, 1, 0, 0, 1, 2, 0);
        expect_char("R3", n0, 8'h07, 0, 0, 0);
        n0 = nval;
        send(8'h40, 7, 1, 0, 1, 1, 2, 0);
        expect_char("R3", n0, 8'h40, 1, 0, 0);
    endtask

    task automatic t_stop;
        int n0;
        fmt = 8'b0000_0111; n0 = nval;              // 8 bits, two-stop setting
        send(8'h12, 8, 0, 0, 0, 1, 0, 0);
        expect_char("R4", n0, 8'h12, 0, 0, 0);
        n0 = nval;
        send(8'h34, 8, 0, 0, 0, 1, 2, 0);
        expect_char("R4", n0, 8'h34, 0, 0, 0);
    endtask

    task automatic t_framing;
        int n0;
        fmt = 8'h03; n0 = nval;
        send(8'h55, 8, 0, 0, 0, 0, 2, 0);
        expect_char("R5", n0, 8'h55, 0, 1, 0);
        n0 = nval;
        send(8'h81, 8, 0, 0, 0, 1, 2, 0);
        expect_char("R5", n0, 8'h81, 0, 0, 0);
    endtask

    task automatic t_break;
        int n0;
        fmt = 8'h03; n0 = nval;
        hold_clk(1'b0, 0, 25 * BITCLK);
        expect_char("R6", n0, 0, 0, 0, 1);
        hold_clk(1'b1, 0, 2 * BITCLK);
        chk("R6", "strobes after mark", nval - n0, 1);
        n0 = nval;
        send(8'h5A, 8, 0, 0, 0, 1, 2, 0);
        expect_char("R6", n0, 8'h5A, 0, 0, 0);
    endtask

    task automatic t_glitch;
        int n0;
        fmt = 8'h03; n0 = nval;
        hold_clk(1'b0, 0, 16);
        hold_clk(1'b1, 0, 3 * BITCLK);
        chk("R7", "strobe after short low", nval - n0, 0);
        n0 = nval;
        send(8'h33, 8, 0, 0, 0, 1, 2, 0);
        expect_char("R7", n0, 8'h33, 0, 0, 0);
    endtask

    task automatic t_loop;
        int n0;
        fmt = 8'h03; n0 = nval;
        loop_en = 1'b1;
        hold_clk(1'b0, 0, 3 * BITCLK);
        chk("R8", "serial_in ignored in loopback", nval - n0, 0);
        send(8'hC3, 8, 0, 0, 0, 1, 2, 1);
        expect_char("R8", n0, 8'hC3, 0, 0, 0);
        loop_en = 1'b0;
        hold_clk(1'b1, 0, 2 * BITCLK);
        n0 = nval;
        send(8'h3C, 8, 0, 0, 0, 1, 2, 1);
        chk("R8", "loop_tx ignored outside loopback", nval - n0, 0);
    endtask

    task automatic t_tick;
        int n0;
        fmt = 8'h03; n0 = nval;
        tick_on = 1'b0;
        send(8'h77, 8, 0, 0, 0, 1, 1, 0);
        chk("R10", "strobe without ticks", nval - n0, 0);
        tick_on = 1'b1;
        hold_clk(1'b1, 0, BITCLK);
        n0 = nval;
        send(8'h11, 8, 0, 0, 0, 1, 2, 0);
        expect_char("R10", n0, 8'h11, 0, 0, 0);
    endtask

    task automatic t_strobe;
        hold_clk(1'b1, 0, 3 * BITCLK);
        chk("R9", "strobe width", maxw, 1);
        chk("R9", "data held", char_data, c_data);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        hold_clk(1'b1, 0, 2 * BITCLK);
        t_lengths();
        t_parity();
        t_stop();
        t_framing();
        t_break();
        t_glitch();
        t_loop();
        t_tick();
        t_strobe();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule